// File: doc/BRIEF.md
# Two-Way Dispatch Stage with Per-Unit Instruction Queues

This block is the dispatch stage of a small superscalar core. Each cycle it looks at a window of up to four pre-decoded instructions, each carrying a 2-bit class tag, a latency flag and a destination id. It retires branches and condition-register operations itself. It also forwards up to two further instructions into a fixed-point queue and a floating-point queue. The two forwarded instructions may be of either class, in any combination. Each queue feeds a modelled execution unit that starts one instruction per cycle. Each unit has a fixed latency, and each unit returns at most one completion per cycle, tagged with the destination id.

The dispatcher walks the window in program order. It stops at the first instruction that cannot go this cycle, and it reports how many leading instructions it consumed. Upstream then shifts its window by that amount. A free-running counter of fixed- and floating-point completions lets a test measure sustained throughput. With an even fixed/float mix the throughput is two per cycle, even when the two classes arrive in runs rather than alternating. A pure fixed-point stream is held to one per cycle.

Top module: `dual_dispatch`

## Requirements
- R1: Window slot k is taken only when every slot below it was taken. An invalid slot ends the scan. `take_cnt` is the number of leading slots consumed in the current cycle. The class code in bits [2k+1:2k] of `win_kind` is 0 for branch, 1 for condition-register, 2 for fixed-point and 3 for floating-point.
- R2: At most one branch and at most one condition-register instruction are consumed per cycle. A second one of the same class ends the scan. A consumed branch raises `br_done` with its id in the following cycle, and a consumed condition-register instruction does the same on `cr_done`. These two classes do not use the forwarding slots.
- R3: At most two fixed/floating instructions are forwarded per cycle, in any mix of the two classes. A third one ends the scan, while branch and condition-register instructions after the two forwarded ones can still be consumed.
- R4: Each unit queue holds QDEPTH entries (default 4). An instruction is forwarded only if its queue has a free entry, judged on the occupancy at the start of the cycle. A blocked instruction ends the scan, even when a later instruction bound for the other queue could go.
- R5: The fixed-point unit starts its queue head every cycle the queue is non-empty. A fixed-point instruction consumed in cycle c into an empty queue appears on `fx_done` in cycle c+2. Completions come out in program order.
- R6: A floating-point instruction with `win_long` bit k at 0 (add type) has latency 2. With that bit at 1 (multiply or multiply-add) it has latency 3. Consumed in cycle c into an idle unit, the result appears on `fp_done` in cycle c+3 or c+4.
- R7: Floating-point starts are delayed when a result would land in the same cycle as an earlier one. A multiply followed directly by an add completes in cycles c+4 and c+5. Floating-point completions come out in program order.
- R8: `retired` counts fixed- and floating-point completions. With unlimited input, an alternating or pairwise-grouped fixed/float stream adds 2 per cycle, and a pure fixed-point stream adds 1 per cycle.
- R9: A synchronous active-high `rst` empties both queues and all in-flight results. It clears every done output and `retired`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | WIN | Per-slot valid bits of the instruction window |
| win_kind | input | 2*WIN | Per-slot class code |
| win_long | input | WIN | Per-slot long-latency floating-point flag |
| win_dest | input | IDW*WIN | Per-slot destination id |
| take_cnt | output | clog2(WIN+1) | Leading slots consumed this cycle |
| br_done | output | 1 | Branch completed |
| br_dest | output | IDW | Id of completed branch |
| cr_done | output | 1 | Condition-register instruction completed |
| cr_dest | output | IDW | Id of completed condition-register instruction |
| fx_done | output | 1 | Fixed-point result |
| fx_dest | output | IDW | Id of fixed-point result |
| fp_done | output | 1 | Floating-point result |
| fp_dest | output | IDW | Id of floating-point result |
| retired | output | CNTW | Count of unit completions since reset |

## Verification
The assertions assume that `rst` is held high through the first clock edge. They also assume that the window changes only between edges, so `take_cnt` is stable when sampled. The bench drives each window as a prefix of a single program-ordered stream and advances it by exactly `take_cnt`. Idle cycles clear every valid bit, never only some, and each id is unique within a run, so the in-order checks can match every completion to one instruction.

// File: rtl/dual_dispatch.sv
`timescale 1ns/1ps
module dual_dispatch #(
  parameter int WIN     = 4,
  parameter int QDEPTH  = 4,
  parameter int IDW     = 8,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 3,
  parameter int CNTW    = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WIN-1:0]           win_valid,
  input  logic [2*WIN-1:0]         win_kind,
  input  logic [WIN-1:0]           win_long,
  input  logic [IDW*WIN-1:0]       win_dest,
  output logic [$clog2(WIN+1)-1:0] take_cnt,
  output logic                     br_done,
  output logic [IDW-1:0]           br_dest,
  output logic                     cr_done,
  output logic [IDW-1:0]           cr_dest,
  output logic                     fx_done,
  output logic [IDW-1:0]           fx_dest,
  output logic                     fp_done,
  output logic [IDW-1:0]           fp_dest,
  output logic [CNTW-1:0]          retired
);
  localparam int CW = $clog2(WIN+1);
  localparam int QW = $clog2(QDEPTH+1);
  localparam int EW = IDW + 1;
  localparam logic [1:0] K_BR = 2'd0, K_CR = 2'd1, K_FX = 2'd2, K_FP = 2'd3;

  logic [QDEPTH-1:0][EW-1:0] fxq, fpq, fxq_n, fpq_n;
  logic [QW-1:0] fx_cnt, fp_cnt, fx_free, fp_free, fx_add, fp_add;
  logic [EW-1:0] fx_w0, fx_w1, fp_w0, fp_w1;
  logic [CW-1:0] took;
  logic [1:0] fwd;
  logic br_take, cr_take, fx_pop, fp_pop;
  logic [IDW-1:0] br_sel, cr_sel;
  logic [LAT_MUL-1:0] slot_v, slot_v_n;
  logic [LAT_MUL-1:0][IDW-1:0] slot_d, slot_d_n;

  assign fx_free = QW'(QDEPTH) - fx_cnt;
  assign fp_free = QW'(QDEPTH) - fp_cnt;
  assign take_cnt = took;

  always_comb begin
    logic stop;
    logic [1:0] kind;
    logic [EW-1:0] ent;
    stop = 1'b0;
    took = '0;
    fwd = '0;
    br_take = 1'b0; br_sel = '0;
    cr_take = 1'b0; cr_sel = '0;
    fx_add = '0; fp_add = '0;
    fx_w0 = '0; fx_w1 = '0; fp_w0 = '0; fp_w1 = '0;
    for (int i = 0; i < WIN; i++) begin
      kind = win_kind[2*i +: 2];
      ent  = {win_long[i], win_dest[IDW*i +: IDW]};
      if (!stop) begin
        if (!win_valid[i]) stop = 1'b1;
        else begin
          case (kind)
            K_BR: if (br_take) stop = 1'b1;
                  else begin br_take = 1'b1; br_sel = ent[IDW-1:0]; took = took + CW'(1); end
            K_CR: if (cr_take) stop = 1'b1;
                  else begin cr_take = 1'b1; cr_sel = ent[IDW-1:0]; took = took + CW'(1); end
            K_FX: if (fwd == 2'd2 || fx_add >= fx_free) stop = 1'b1;
                  else begin
                    if (fx_add == '0) fx_w0 = ent; else fx_w1 = ent;
                    fx_add = fx_add + QW'(1); fwd = fwd + 2'd1; took = took + CW'(1);
                  end
            K_FP: if (fwd == 2'd2 || fp_add >= fp_free) stop = 1'b1;
                  else begin
                    if (fp_add == '0) fp_w0 = ent; else fp_w1 = ent;
                    fp_add = fp_add + QW'(1); fwd = fwd + 2'd1; took = took + CW'(1);
                  end
          endcase
        end
      end
    end
  end

  function automatic logic [QDEPTH-1:0][EW-1:0] q_next(
    input logic [QDEPTH-1:0][EW-1:0] q,
    input logic                      pop,
    input logic [QW-1:0]             cnt,
    input logic [QW-1:0]             add,
    input logic [EW-1:0]             w0,
    input logic [EW-1:0]             w1);
    logic [QDEPTH-1:0][EW-1:0] r;
    logic [QW-1:0] base;
    r = q;
    if (pop) for (int k = 0; k < QDEPTH-1; k++) r[k] = q[k+1];
    base = cnt - QW'(pop);
    for (int k = 0; k < QDEPTH; k++) begin
      if (QW'(k) == base && add != '0) r[k] = w0;
      if (QW'(k) == base + QW'(1) && add == QW'(2)) r[k] = w1;
    end
    return r;
  endfunction

  assign fx_pop = fx_cnt != '0;
  assign fp_pop = (fp_cnt != '0) && !(!fpq[0][IDW] && slot_v[LAT_ADD]);
  assign fxq_n  = q_next(fxq, fx_pop, fx_cnt, fx_add, fx_w0, fx_w1);
  assign fpq_n  = q_next(fpq, fp_pop, fp_cnt, fp_add, fp_w0, fp_w1);

  always_comb begin
    slot_v_n = slot_v >> 1;
    slot_d_n = slot_d >> IDW;
    if (fp_pop) begin
      if (fpq[0][IDW]) begin
        slot_v_n[LAT_MUL-1] = 1'b1;
        slot_d_n[LAT_MUL-1] = fpq[0][IDW-1:0];
      end else begin
        slot_v_n[LAT_ADD-1] = 1'b1;
        slot_d_n[LAT_ADD-1] = fpq[0][IDW-1:0];
      end
    end
  end

  assign fp_done = slot_v[0];
  assign fp_dest = slot_d[0];

  always_ff @(posedge clk) begin
    fxq     <= fxq_n;
    fpq     <= fpq_n;
    slot_d  <= slot_d_n;
    br_dest <= br_sel;
    cr_dest <= cr_sel;
    fx_dest <= fxq[0][IDW-1:0];
    if (rst) begin
      fx_cnt  <= '0;
      fp_cnt  <= '0;
      slot_v  <= '0;
      br_done <= 1'b0;
      cr_done <= 1'b0;
      fx_done <= 1'b0;
      retired <= '0;
    end else begin
      fx_cnt  <= fx_cnt - QW'(fx_pop) + fx_add;
      fp_cnt  <= fp_cnt - QW'(fp_pop) + fp_add;
      slot_v  <= slot_v_n;
      br_done <= br_take;
      cr_done <= cr_take;
      fx_done <= fx_pop;
      retired <= retired + CNTW'(fx_done) + CNTW'(slot_v[0]);
    end
  end
endmodule

// File: rtl/dual_dispatch_checker.sv
`timescale 1ns/1ps
module dual_dispatch_checker #(
  parameter int WIN    = 4,
  parameter int QDEPTH = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [WIN-1:0]           win_valid,
  input logic [$clog2(WIN+1)-1:0] take_cnt,
  input logic [$clog2(QDEPTH+1)-1:0] fx_cnt,
  input logic [$clog2(QDEPTH+1)-1:0] fp_cnt,
  input logic                     br_done,
  input logic                     cr_done,
  input logic                     fx_done,
  input logic                     fp_done
);
  a_r1_take_bound: assert property (@(posedge clk) disable iff (rst)
    int'(take_cnt) <= WIN);

  a_r1_hole_stops: assert property (@(posedge clk) disable iff (rst)
    !win_valid[0] |-> take_cnt == '0);

  a_r2_done_needs_take: assert property (@(posedge clk) disable iff (rst)
    (br_done || cr_done) |-> $past(take_cnt) != '0);

  a_r4_fx_bound: assert property (@(posedge clk) disable iff (rst)
    int'(fx_cnt) <= QDEPTH);

  a_r4_fp_bound: assert property (@(posedge clk) disable iff (rst)
    int'(fp_cnt) <= QDEPTH);

  a_r5_fx_busy: assert property (@(posedge clk) disable iff (rst)
    fx_cnt != '0 |=> fx_done);

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (fx_cnt == '0 && fp_cnt == '0 && !fx_done && !fp_done && !br_done && !cr_done));
endmodule

bind dual_dispatch dual_dispatch_checker #(.WIN(WIN), .QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst(rst), .win_valid(win_valid), .take_cnt(take_cnt),
  .fx_cnt(fx_cnt), .fp_cnt(fp_cnt), .br_done(br_done), .cr_done(cr_done),
  .fx_done(fx_done), .fp_done(fp_done));

// File: tb/dual_dispatch_bench.sv
`timescale 1ns/1ps
module dual_dispatch_bench;
  localparam int WIN = 4, IDW = 8, N = 200;
  localparam logic [1:0] BR = 2'd0, CR = 2'd1, FX = 2'd2, FP = 2'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic [WIN-1:0] wv = '0, wl = '0;
  logic [2*WIN-1:0] wk = '0;
  logic [IDW*WIN-1:0] wd = '0;
  logic [2:0] take;
  logic br_done, cr_done, fx_done, fp_done;
  logic [IDW-1:0] br_dest, cr_dest, fx_dest, fp_dest;
  logic [15:0] retired;

  int errors = 0, checks = 0, cyc = 0;
  logic [1:0] s_kind [N];
  bit s_long [N];
  int bp [4];

  always #2.5 clk = ~clk;

  dual_dispatch u_dual_dispatch (
    .clk(clk), .rst(rst), .win_valid(wv), .win_kind(wk), .win_long(wl), .win_dest(wd),
    .take_cnt(take), .br_done(br_done), .br_dest(br_dest), .cr_done(cr_done), .cr_dest(cr_dest),
    .fx_done(fx_done), .fx_dest(fx_dest), .fp_done(fp_done), .fp_dest(fp_dest), .retired(retired));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic clear_win(); wv = '0; wk = '0; wl = '0; wd = '0; endtask
  task automatic put(int k, logic [1:0] kd, bit lg, int d);
    wv[k] = 1'b1; wk[2*k +: 2] = kd; wl[k] = lg; wd[IDW*k +: IDW] = IDW'(d);
  endtask
  task automatic do_reset(); rst = 1'b1; clear_win(); step(); step(); rst = 1'b0; endtask

  function automatic logic [1:0] pat_kind(int pat, int i);
    if (pat == 0) return (i % 2 == 1) ? FP : FX;
    if (pat == 1) return ((i / 2) % 2 == 1) ? FP : FX;
    return FX;
  endfunction

  task automatic rate(int pat, output int delta);
    int s, r0;
    s = 0; r0 = 0; delta = 0;
    do_reset();
    for (int c = 0; c < 100; c++) begin
      clear_win();
      for (int k = 0; k < WIN; k++) put(k, pat_kind(pat, s + k), 1'b0, (s + k) % 256);
      #1;
      if (c == 20) r0 = int'(retired);
      if (c == 84) delta = int'(retired) - r0;
      s += int'(take);
      step();
    end
  endtask

  task automatic match(int k, logic [IDW-1:0] d, string req);
    int j;
    j = bp[k];
    while (j < N && s_kind[j] != 2'(k)) j++;
    chk(j < N && int'(d) == j, req, int'(d), j);
    bp[k] = j + 1;
  endtask

  initial begin
    int d, ptr, units, drain;
    int exp_fp [6];
    void'($urandom(32'd20240611));
    step();
    do_reset();

    // R9 / R1: reset state, empty window
    #1;
    chk(take == 0, "R1 empty window", int'(take), 0);
    chk(!br_done && !cr_done && !fx_done && !fp_done, "R9 done outputs after reset",
        int'({br_done, cr_done, fx_done, fp_done}), 0);
    chk(retired == 0, "R9 retired after reset", int'(retired), 0);

    // R1 R2 R5 R6: one of each class
    put(0, BR, 0, 1); put(1, CR, 0, 2); put(2, FX, 0, 3); put(3, FP, 0, 4);
    #1; chk(take == 4, "R1 mixed window", int'(take), 4);
    step(); clear_win();
    chk(br_done && br_dest == 1, "R2 branch done", int'(br_dest), 1);
    chk(cr_done && cr_dest == 2, "R2 cr done", int'(cr_dest), 2);
    chk(!fx_done, "R5 fx not yet", int'(fx_done), 0);
    step();
    chk(fx_done && fx_dest == 3, "R5 fx at c+2", int'(fx_dest), 3);
    chk(!fp_done, "R6 add not yet", int'(fp_done), 0);
    step();
    chk(fp_done && fp_dest == 4, "R6 add at c+3", int'(fp_dest), 4);

    // R2: second branch / second cr ends scan
    do_reset();
    put(0, BR, 0, 5); put(1, BR, 0, 6); put(2, FX, 0, 7); put(3, FX, 0, 8);
    #1; chk(take == 1, "R2 two branches", int'(take), 1);
    clear_win(); put(0, CR, 0, 5); put(1, BR, 0, 6); put(2, CR, 0, 7); put(3, FX, 0, 8);
    #1; chk(take == 2, "R2 two cr", int'(take), 2);

    // R3: forward limit
    clear_win(); put(0, FX, 0, 1); put(1, FP, 0, 2); put(2, FX, 0, 3); put(3, FX, 0, 4);
    #1; chk(take == 2, "R3 third forward stops", int'(take), 2);
    clear_win(); put(0, FX, 0, 1); put(1, FX, 0, 2); put(2, BR, 0, 3); put(3, CR, 0, 4);
    #1; chk(take == 4, "R3 br/cr after two forwards", int'(take), 4);
    clear_win(); put(0, FP, 1, 1); put(1, FP, 0, 2); put(2, FP, 0, 3); put(3, BR, 0, 4);
    #1; chk(take == 2, "R3 two floats then stop", int'(take), 2);

    // R1: hole in the window
    clear_win(); put(0, FX, 0, 1); put(2, FX, 0, 3); put(3, FX, 0, 4);
    #1; chk(take == 1, "R1 hole ends scan", int'(take), 1);
    clear_win(); put(1, FX, 0, 1);
    #1; chk(take == 0, "R1 slot0 invalid", int'(take), 0);

    // R6 R7: multiply then add, result collision
    do_reset();
    put(0, FP, 1, 10); put(1, FP, 0, 11);
    #1; chk(take == 2, "R7 mul add take", int'(take), 2);
    exp_fp = '{0, 0, 0, 0, 10, 11};
    for (int t = 1; t <= 5; t++) begin
      step(); clear_win();
      if (exp_fp[t] == 0) chk(!fp_done, "R7 fp idle slot", int'(fp_done), 0);
      else chk(fp_done && int'(fp_dest) == exp_fp[t], "R6 R7 fp latency", int'(fp_dest), exp_fp[t]);
    end

    // R4: queue fills, blocked fx stops scan before free fp
    do_reset();
    for (int k = 0; k < WIN; k++) put(k, FX, 0, k);
    #1; chk(take == 2, "R4 fill 1", int'(take), 2);
    step();
    #1; chk(take == 2, "R4 fill 2", int'(take), 2);
    step();
    clear_win(); put(0, FX, 0, 20); put(1, FX, 0, 21); put(2, FP, 0, 22); put(3, FP, 0, 23);
    #1; chk(take == 1, "R4 full queue blocks in order", int'(take), 1);
    step(); clear_win();

    // R9: reset with work in flight
    rst = 1'b1; step(); rst = 1'b0;
    d = 0;
    for (int t = 0; t < 5; t++) begin
      if (fx_done || fp_done) d++;
      step();
    end
    chk(d == 0, "R9 no results after reset", d, 0);
    chk(retired == 0, "R9 counter cleared", int'(retired), 0);

    // R8: sustained rates
    rate(0, d); chk(d == 128, "R8 alternating mix", d, 128);
    rate(1, d); chk(d == 128, "R8 grouped mix", d, 128);
    rate(2, d); chk(d == 64, "R8 pure fixed", d, 64);

    // R2 R5 R7 R8: random stream, in-order completion per unit
    for (int i = 0; i < N; i++) begin
      s_kind[i] = 2'($urandom % 4);
      s_long[i] = 1'($urandom % 2);
    end
    for (int k = 0; k < 4; k++) bp[k] = 0;
    do_reset();
    ptr = 0; units = 0; drain = 0;
    for (int c = 0; c < 3000 && drain < 20; c++) begin
      if (br_done) match(0, br_dest, "R2 branch order");
      if (cr_done) match(1, cr_dest, "R2 cr order");
      if (fx_done) begin match(2, fx_dest, "R5 fx order"); units++; end
      if (fp_done) begin match(3, fp_dest, "R7 fp order"); units++; end
      clear_win();
      if ($urandom % 8 != 0)
        for (int k = 0; k < WIN; k++)
          if (ptr + k < N) put(k, s_kind[ptr + k], s_long[ptr + k], ptr + k);
      #1;
      ptr += int'(take);
      if (ptr >= N) drain++;
      step();
    end
    for (int k = 0; k < 4; k++) begin
      int j;
      j = bp[k];
      while (j < N && s_kind[j] != 2'(k)) j++;
      chk(j == N, "R7 every instruction completed", j, N);
    end
    chk(int'(retired) == units, "R8 counter matches completions", int'(retired), units);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule